// File: doc/BRIEF.md
# Overcurrent Latch-Off Timer

This block guards a multiphase buck regulator against overload. Each clock cycle it takes a digitized total-current code, the active power-state code, the phase count configured for full-power operation, the output-voltage and reference-voltage codes, and an enable. It compares the current against two limits: a moderate limit that must be exceeded for an unbroken run of cycles before it trips, and a severe limit that trips on the first cycle it is exceeded.

A trip sets a latched shutdown. The latch drops the gate-driver enable at once and drops power-good a few cycles later. It records whether the delayed or the immediate limit caused the shutdown. Only dropping the enable releases the latch.

In the full-power state both limits have their base values. In any low-power state both limits are divided by the configured phase count, taken from tables built when the design is elaborated. Protection arms only after the output or the reference rises above a minimum level. A start into a shorted or discharged output therefore cannot trip it falsely.

Top module: `ocp_latchoff`

## Requirements
- R1: After reset, and in every cycle with enable low, `shutdown_o` is 0, `trip_cause_o` is 2'b00 and `pgood_o` is 0. `drive_en_o` equals `enable_i` whenever no shutdown is latched.
- R2: Protection arms at the first clock edge where `vout_i` > ARM_VOUT (25, 10 mV steps) or `vref_i` > ARM_VREF (30) with enable high. It stays armed until enable goes low. No current value latches a shutdown while the block is unarmed, and `pgood_o` is high only while the block is armed and enabled.
- R3: With the block armed, a current strictly above the moderate limit at DLY_CYC (50) consecutive clock edges latches a shutdown at the 50th edge, with `trip_cause_o` = 2'b01.
- R4: A current at or below the moderate limit at any edge clears the consecutive-cycle count, so a run of 49 edges followed by one low sample does not trip.
- R5: With the block armed, a current strictly above the severe limit latches a shutdown at that same edge, with `trip_cause_o` = 2'b10. When both limits are met at one edge, the immediate cause wins.
- R6: With `pstate_i` = 0 (full power), the moderate limit is 120 and the severe limit is 180, whatever the phase count. A current equal to a limit does not exceed it.
- R7: With `pstate_i` = 1, 2 or 3, the limits are 120/N and 180/N with integer truncation, where N is the configured phase count: 120/180, 60/90, 40/60 or 30/45 for N = 1 to 4.
- R8: A `phases_i` value of 0 is used as N = 1, and a value above 4 is used as N = 4.
- R9: A latched shutdown holds `shutdown_o` = 1 and `drive_en_o` = 0 for any current, voltage or power state. It clears only at a clock edge with enable low.
- R10: `pgood_o` falls exactly PG_DLY (5) cycles after `shutdown_o` rises.
- R11: `trip_cause_o` holds its value for as long as the shutdown stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Regulator enable; low clears the latch and the arming |
| cur_i | input | 8 | Total-current code |
| pstate_i | input | 2 | Power state, 0 = full power |
| phases_i | input | 3 | Phase count configured for full power |
| vout_i | input | 8 | Output-voltage code, 10 mV per step |
| vref_i | input | 8 | Reference-voltage code, 10 mV per step |
| drive_en_o | output | 1 | Gate-driver enable |
| pgood_o | output | 1 | Power-good |
| shutdown_o | output | 1 | Latched overcurrent shutdown |
| trip_cause_o | output | 2 | 00 none, 01 delayed limit, 10 immediate limit |

## Verification
Directed runs place the current one code above and exactly at each limit. They do this for full power and for every low-power divisor, so a wrong table entry or a non-strict compare shows up as a trip or a missed trip. Runs of 49 over-limit edges broken by one low sample, against unbroken runs of 50, separate a correct counter reset and terminal count from off-by-one errors. A moderate run that ends in a severe sample checks the cause priority. Unarmed overloads and out-of-range phase counts check the arming gate and the clamp. Seeded random bursts of current, held for random lengths around the limits, then mix state changes and enable toggles. A cycle model in the bench checks every output at every cycle.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_DELAY = 2'b01,
    CAUSE_IMM   = 2'b10
  } trip_cause_e;

  localparam logic [1:0] PS_FULL = 2'd0;
endpackage

// File: rtl/ocp_limit_sel.sv
module ocp_limit_sel #(
  parameter int CUR_W    = 8,
  parameter int PH_W     = 3,
  parameter int MAX_PH   = 4,
  parameter int BASE_LIM = 120
) (
  input  logic [1:0]       pstate_i,
  input  logic [PH_W-1:0]  phases_i,
  input  logic [CUR_W-1:0] cur_i,
  output logic             over_mod_o,
  output logic             over_sev_o
);
  import ocp_pkg::*;

  localparam int SEV_LIM = (BASE_LIM * 3) / 2;
  localparam int IDX_W   = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;

  logic [CUR_W-1:0] mod_tab [MAX_PH];
  logic [CUR_W-1:0] sev_tab [MAX_PH];
  logic [IDX_W-1:0] idx;
  logic [CUR_W-1:0] mod_lim, sev_lim;

  // per-divisor limits fixed at elaboration, no runtime divider
  for (genvar g = 0; g < MAX_PH; g++) begin : g_tab
    assign mod_tab[g] = CUR_W'(BASE_LIM / (g + 1));
    assign sev_tab[g] = CUR_W'(SEV_LIM / (g + 1));
  end

  always_comb begin
    if (phases_i == '0)
      idx = '0;
    else if (int'(phases_i) > MAX_PH)
      idx = IDX_W'(MAX_PH - 1);
    else
      idx = IDX_W'(phases_i - 1'b1);
  end

  always_comb begin
    if (pstate_i == PS_FULL) begin
      mod_lim = CUR_W'(BASE_LIM);
      sev_lim = CUR_W'(SEV_LIM);
    end else begin
      mod_lim = mod_tab[idx];
      sev_lim = sev_tab[idx];
    end
  end

  assign over_mod_o = cur_i > mod_lim;
  assign over_sev_o = cur_i > sev_lim;

  // R7
  always_comb begin
    lim_order_chk: assert (sev_lim >= mod_lim);
  end
endmodule

// File: rtl/ocp_arm.sv
module ocp_arm #(
  parameter int V_W      = 8,
  parameter int ARM_VOUT = 25,
  parameter int ARM_VREF = 30
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           enable_i,
  input  logic [V_W-1:0] vout_i,
  input  logic [V_W-1:0] vref_i,
  output logic           armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      armed_q <= 1'b0;
    else if (!enable_i)
      armed_q <= 1'b0;
    else if (vout_i > V_W'(ARM_VOUT) || vref_i > V_W'(ARM_VREF))
      armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  // R2
  arm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && enable_i |=> armed_q);
endmodule

// File: rtl/ocp_trip_timer.sv
module ocp_trip_timer #(
  parameter int DLY_CYC = 50
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enable_i,
  input  logic                  armed_i,
  input  logic                  over_mod_i,
  input  logic                  over_sev_i,
  output logic                  latched_o,
  output ocp_pkg::trip_cause_e  cause_o
);
  import ocp_pkg::*;

  localparam int CNT_W = $clog2(DLY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DLY_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             latched_q;
  trip_cause_e      cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      latched_q <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else if (!enable_i) begin
      cnt_q     <= '0;
      latched_q <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else if (!latched_q && armed_i) begin
      if (over_sev_i) begin
        latched_q <= 1'b1;
        cause_q   <= CAUSE_IMM;
        cnt_q     <= '0;
      end else if (over_mod_i) begin
        if (cnt_q == CNT_LAST) begin
          latched_q <= 1'b1;
          cause_q   <= CAUSE_DELAY;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign latched_o = latched_q;
  assign cause_o   = cause_q;

  // R3
  delay_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched_q) && cause_q == CAUSE_DELAY |-> $past(cnt_q) == CNT_LAST);
  // R5
  imm_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && armed_i && !latched_q && over_sev_i |=> latched_q && cause_q == CAUSE_IMM);
  // R9
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_q && enable_i |=> latched_q);
  // R2
  unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i && !latched_q |=> !latched_q);
  // R11
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_q && enable_i |=> $stable(cause_q));
  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/ocp_pg_delay.sv
module ocp_pg_delay #(
  parameter int PG_DLY = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic latched_i,
  output logic pg_drop_o
);
  localparam int PG_W = $clog2(PG_DLY + 1);
  localparam logic [PG_W-1:0] PG_END = PG_W'(PG_DLY);

  logic [PG_W-1:0] pg_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      pg_cnt_q <= '0;
    else if (!enable_i || !latched_i)
      pg_cnt_q <= '0;
    else if (pg_cnt_q != PG_END)
      pg_cnt_q <= pg_cnt_q + 1'b1;
  end

  assign pg_drop_o = (pg_cnt_q == PG_END);

  // R10
  pg_after_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_drop_o |-> latched_i);
endmodule

// File: rtl/ocp_latchoff.sv
module ocp_latchoff #(
  parameter int CUR_W    = 8,
  parameter int V_W      = 8,
  parameter int PH_W     = 3,
  parameter int MAX_PH   = 4,
  parameter int BASE_LIM = 120,
  parameter int DLY_CYC  = 50,
  parameter int PG_DLY   = 5,
  parameter int ARM_VOUT = 25,
  parameter int ARM_VREF = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CUR_W-1:0] cur_i,
  input  logic [1:0]       pstate_i,
  input  logic [PH_W-1:0]  phases_i,
  input  logic [V_W-1:0]   vout_i,
  input  logic [V_W-1:0]   vref_i,
  output logic             drive_en_o,
  output logic             pgood_o,
  output logic             shutdown_o,
  output logic [1:0]       trip_cause_o
);
  import ocp_pkg::*;

  logic        over_mod, over_sev, armed, latched, pg_drop;
  trip_cause_e cause;

  ocp_limit_sel #(
    .CUR_W(CUR_W), .PH_W(PH_W), .MAX_PH(MAX_PH), .BASE_LIM(BASE_LIM)
  ) u_lim (
    .pstate_i  (pstate_i),
    .phases_i  (phases_i),
    .cur_i     (cur_i),
    .over_mod_o(over_mod),
    .over_sev_o(over_sev)
  );

  ocp_arm #(
    .V_W(V_W), .ARM_VOUT(ARM_VOUT), .ARM_VREF(ARM_VREF)
  ) u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .vout_i  (vout_i),
    .vref_i  (vref_i),
    .armed_o (armed)
  );

  ocp_trip_timer #(.DLY_CYC(DLY_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .armed_i   (armed),
    .over_mod_i(over_mod),
    .over_sev_i(over_sev),
    .latched_o (latched),
    .cause_o   (cause)
  );

  ocp_pg_delay #(.PG_DLY(PG_DLY)) u_pg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .latched_i(latched),
    .pg_drop_o(pg_drop)
  );

  assign drive_en_o   = enable_i & ~latched;
  assign pgood_o      = enable_i & armed & ~pg_drop;
  assign shutdown_o   = latched;
  assign trip_cause_o = cause;

  // R10
  pg_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> pgood_o);
  // R9
  drv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> !drive_en_o);
  // R11
  cause_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trip_cause_o));
endmodule

// File: tb/ocp_latchoff_test.sv
`timescale 1ns/1ps
module ocp_latchoff_test;
  localparam int DLY = 50;
  localparam int PGD = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] cur = '0;
  logic [1:0] ps = '0;
  logic [2:0] ph = 3'd4;
  logic [7:0] vo = '0;
  logic [7:0] vr = '0;
  logic       drv, pg, sd;
  logic [1:0] cz;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";

  // model state
  bit m_arm, m_lat;
  int m_cnt, m_pg;
  logic [1:0] m_cause;

  always #10 clk = ~clk;

  ocp_latchoff uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .cur_i(cur), .pstate_i(ps),
    .phases_i(ph), .vout_i(vo), .vref_i(vr), .drive_en_o(drv), .pgood_o(pg),
    .shutdown_o(sd), .trip_cause_o(cz)
  );

  function automatic int lim_of(input int p, input int n, input bit sev);
    int nn, b;
    nn = (n == 0) ? 1 : (n > 4 ? 4 : n);
    b  = sev ? 180 : 120;
    return (p == 0) ? b : b / nn;
  endfunction

  task automatic model_step();
    bit old_arm, old_lat;
    old_arm = m_arm;
    old_lat = m_lat;
    if (!en) begin
      m_arm = 0; m_lat = 0; m_cnt = 0; m_pg = 0; m_cause = 2'b00;
    end else begin
      if (vo > 25 || vr > 30) m_arm = 1;
      if (old_lat) begin
        if (m_pg < PGD) m_pg++;
      end else if (old_arm) begin
        if (cur > lim_of(ps, ph, 1)) begin
          m_lat = 1; m_cause = 2'b10; m_cnt = 0;
        end else if (cur > lim_of(ps, ph, 0)) begin
          if (m_cnt == DLY - 1) begin
            m_lat = 1; m_cause = 2'b01; m_cnt = 0;
          end else m_cnt++;
        end else m_cnt = 0;
      end else m_cnt = 0;
    end
  endtask

  task automatic compare();
    logic e_drv, e_pg;
    e_drv = en & ~m_lat;
    e_pg  = en & m_arm & ~(m_lat && m_pg == PGD);
    n_chk++;
    if (drv !== e_drv || pg !== e_pg || sd !== m_lat || cz !== m_cause) begin
      n_fail++;
      $display("FAIL %s t=%0t drv/pg/sd/cause act=%b%b%b%b exp=%b%b%b%b",
               tag, $time, drv, pg, sd, cz, e_drv, e_pg, m_lat, m_cause);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic hold(input int c, input int n);
    cur = 8'(c);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rearm();
    en = 1'b0; cur = '0;
    tick();
    en = 1'b1; vr = 8'd31;
    tick();
    tick();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    n_chk++;
    if (drv !== 1'b0 || pg !== 1'b0 || sd !== 1'b0 || cz !== 2'b00) begin
      n_fail++;
      $display("FAIL R1 reset act=%b%b%b%b exp=0000", drv, pg, sd, cz);
    end
    rst_n = 1'b1;
    tag = "R1"; tick(); tick();
    en = 1'b1;
    // unarmed overload never trips
    tag = "R2"; hold(200, 60);
    vr = 8'd30; vo = 8'd25; hold(200, 5);
    cur = '0; vr = 8'd31; tick(); tick();
    // at-limit is not over
    tag = "R6"; hold(120, 80);
    tag = "R4"; hold(121, 49); hold(0, 1); hold(121, 49); hold(0, 2);
    tag = "R3"; hold(121, 50);
    tag = "R10"; hold(121, 10);
    tag = "R9"; hold(0, 10); hold(200, 3); ps = 2'd1; hold(0, 3); ps = 2'd0;
    tag = "R11"; hold(0, 4);
    rearm();
    tag = "R5"; hold(181, 1); hold(0, 8);
    rearm();
    tag = "R6"; ph = 3'd2; hold(180, 10); hold(181, 2);
    rearm();
    tag = "R5"; hold(150, 49); hold(181, 1); hold(0, 3);
    rearm();
    tag = "R7"; ps = 2'd2; ph = 3'd4; hold(30, 60); hold(31, 50); hold(0, 2);
    rearm();
    tag = "R7"; hold(45, 5); hold(46, 2);
    rearm();
    tag = "R7"; ps = 2'd1; ph = 3'd3; hold(40, 55); hold(60, 5); hold(61, 2);
    rearm();
    tag = "R7"; ps = 2'd3; ph = 3'd2; hold(61, 50); hold(0, 2);
    rearm();
    tag = "R8"; ps = 2'd3; ph = 3'd0; hold(120, 55); hold(121, 50); hold(0, 2);
    rearm();
    tag = "R8"; ps = 2'd1; ph = 3'd7; hold(45, 5); hold(46, 2);
    rearm();
    tag = "R2"; en = 1'b0; tick(); en = 1'b1; vr = 8'd0; vo = 8'd26; tick(); hold(200, 2);
    tag = "R1"; en = 1'b0; hold(200, 4);
    // random bursts around the limits
    tag = "RND"; en = 1'b1;
    for (int b = 0; b < 1500; b++) begin
      int len, pick;
      len  = 1 + int'($urandom_range(70));
      pick = int'($urandom_range(5));
      if ($urandom_range(30) == 0) en = ~en;
      if ($urandom_range(8) == 0) ps = 2'($urandom_range(3));
      if ($urandom_range(8) == 0) ph = 3'($urandom_range(7));
      vo = 8'($urandom_range(40));
      vr = 8'($urandom_range(40));
      case (pick)
        0: cur = 8'(lim_of(ps, ph, 0));
        1: cur = 8'(lim_of(ps, ph, 0) + 1);
        2: cur = 8'(lim_of(ps, ph, 1));
        3: cur = 8'(lim_of(ps, ph, 1) + 1);
        default: cur = 8'($urandom_range(255));
      endcase
      for (int i = 0; i < len; i++) tick();
      if ($urandom_range(4) == 0) en = 1'b1;
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule